// File: doc/BRIEF.md
# Single-Cycle Integer Arithmetic Datapath

This block is a small single-cycle execution core for integer add, subtract and compare instructions. In every clock cycle it presents its program counter on an instruction-fetch address port and takes back one 32-bit instruction word. Within the same cycle it decodes the word, reads two source registers and computes the result. It then commits the result to a 32-entry register file on the next rising edge and steps the program counter by four.

Register-format instructions take both operands from the register file and write the register named in bits 15:11. Immediate-format instructions replace the second operand with an extended 16-bit constant and write the register named in bits 20:16. The trapping forms (add, sub, addi) do not raise an exception on signed overflow. Instead they raise a flag output for that cycle and drop the write. The wrapping forms give the same bit result and never raise the flag.

The write-back port shows, in each cycle, whether the current instruction writes, which register it writes and what value. This lets a surrounding design or a bench follow the architectural state without reaching inside the block.

Top module: `arith_core`

## Requirements
- R1: A synchronous active-high `rst` sets the program counter to 0. `imem_addr` always shows the program counter. After every cycle out of reset the counter grows by 4, wrapping modulo 2^32, whatever instruction was fetched.
- R2: The register file has 32 registers of 32 bits. Register 0 always reads as zero. An instruction that targets register 0 still shows `wb_en` high, but register 0 keeps reading zero afterwards.
- R3: Decoding uses the field positions opcode = bits 31:26, rs = 25:21, rt = 20:16, rd = 15:11 and funct = 5:0. The register-format instructions have opcode 0 with funct 0x20 add, 0x21 addu, 0x22 sub, 0x23 subu, 0x2A slt and 0x2B sltu. The immediate-format opcodes are 0x08 addi, 0x09 addiu, 0x0A slti and 0x0B sltiu. Any other word is a no-op: `wb_en` and `ovf_flag` stay low and only the program counter moves.
- R4: add/addu write rs+rt and sub/subu write rs-rt, both modulo 2^32. addu and subu never raise `ovf_flag`.
- R5: `ovf_flag` rises during the cycle of add, sub or addi when the exact signed result does not fit in 32 bits. In that cycle `wb_en` is low and the destination register keeps its old value.
- R6: slt/slti write 1 when rs is smaller than the second operand as signed integers, and 0 otherwise. sltu/sltiu make the same comparison on unsigned values.
- R7: The immediate forms use rs and the 16-bit immediate in bits 15:0, sign-extended by copying bit 15 into bits 31:16. This holds for addiu and sltiu too, under the default parameters. Their result goes to rt.
- R8: sub with rs = 0 yields 0 - rt. It raises `ovf_flag` only for rt = 0x80000000. subu with rs = 0 returns 0x80000000 for that operand.
- R9: `wb_en`, `wb_addr` and `wb_data` describe the write of the instruction currently on `imem_data`, combinationally. A register written on a rising edge is seen by the next instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset of the program counter |
| imem_addr | output | 32 | Fetch address, equal to the program counter |
| imem_data | input | 32 | Instruction word returned for `imem_addr` |
| wb_en | output | 1 | The current instruction writes a register at the next edge |
| wb_addr | output | 5 | Destination register of the current instruction |
| wb_data | output | 32 | Value that will be written |
| ovf_flag | output | 1 | Signed overflow of a trapping instruction in this cycle |

## Verification
Some properties are checked by the bound assertions on every cycle. These are the program-counter step and its reset value, the zero reading of register 0 on both read ports, and the silence of illegal words. They also cover the write suppression under overflow, the absence of overflow on the wrapping forms, and the single-bit result of the compares. Other behaviour can only be shown by the bench's scenarios against its own register model. This covers the arithmetic values, immediate extension, the wrap of addiu against the overflow of addi, negation through register 0, and a write reaching the next instruction or being dropped.

// File: rtl/arith_pkg.sv
package arith_pkg;

  localparam int XLEN   = 32;
  localparam int REG_AW = 5;
  localparam int IMM_W  = 16;
  localparam int OPC_W  = 6;

  localparam logic [OPC_W-1:0] OPC_REG   = 6'h00;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
  localparam logic [OPC_W-1:0] OPC_ADDIU = 6'h09;
  localparam logic [OPC_W-1:0] OPC_SLTI  = 6'h0A;
  localparam logic [OPC_W-1:0] OPC_SLTIU = 6'h0B;

  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_SUBU = 6'h23;
  localparam logic [5:0] FN_SLT  = 6'h2A;
  localparam logic [5:0] FN_SLTU = 6'h2B;

  typedef enum logic [2:0] {
    ALU_NONE,
    ALU_ADD,
    ALU_SUB,
    ALU_SLT,
    ALU_SLTU
  } alu_op_e;

  typedef struct packed {
    logic              legal;
    alu_op_e           op;
    logic              trap;
    logic              use_imm;
    logic              zext;
    logic [REG_AW-1:0] dst;
  } dec_t;

  function automatic logic [XLEN-1:0] extend_imm(input logic [IMM_W-1:0] imm,
                                                 input logic zext);
    logic fill;
    fill = zext ? 1'b0 : imm[IMM_W-1];
    return {{(XLEN-IMM_W){fill}}, imm};
  endfunction

  // Same operand signs and a result sign that differs from them.
  function automatic logic add_overflows(input logic [XLEN-1:0] a,
                                         input logic [XLEN-1:0] b,
                                         input logic [XLEN-1:0] s);
    return (a[XLEN-1] == b[XLEN-1]) && (s[XLEN-1] != a[XLEN-1]);
  endfunction

  // Operand signs differ and the result sign differs from the minuend.
  function automatic logic sub_overflows(input logic [XLEN-1:0] a,
                                         input logic [XLEN-1:0] b,
                                         input logic [XLEN-1:0] d);
    return (a[XLEN-1] != b[XLEN-1]) && (d[XLEN-1] != a[XLEN-1]);
  endfunction

  function automatic logic less_signed(input logic [XLEN-1:0] a,
                                       input logic [XLEN-1:0] b);
    return $signed(a) < $signed(b);
  endfunction

endpackage

// File: rtl/arith_decode.sv
module arith_decode
  import arith_pkg::*;
#(
  parameter bit ZEXT_UNSIGNED_IMM = 1'b0
) (
  input  logic [XLEN-1:0] instr,
  output dec_t            dec
);

  logic [OPC_W-1:0]  opcode;
  logic [5:0]        funct;
  logic [REG_AW-1:0] rt_f;
  logic [REG_AW-1:0] rd_f;
  logic              unused_shamt;

  assign opcode       = instr[31:26];
  assign funct        = instr[5:0];
  assign rt_f         = instr[20:16];
  assign rd_f         = instr[15:11];
  assign unused_shamt = ^instr[10:6];

  always_comb begin
    dec         = '0;
    dec.op      = ALU_NONE;
    unique case (opcode)
      OPC_REG: begin
        dec.dst = rd_f;
        unique case (funct)
          FN_ADD:  begin dec.legal = 1'b1; dec.op = ALU_ADD;  dec.trap = 1'b1; end
          FN_ADDU: begin dec.legal = 1'b1; dec.op = ALU_ADD;                   end
          FN_SUB:  begin dec.legal = 1'b1; dec.op = ALU_SUB;  dec.trap = 1'b1; end
          FN_SUBU: begin dec.legal = 1'b1; dec.op = ALU_SUB;                   end
          FN_SLT:  begin dec.legal = 1'b1; dec.op = ALU_SLT;                   end
          FN_SLTU: begin dec.legal = 1'b1; dec.op = ALU_SLTU;                  end
          default: dec.legal = 1'b0;
        endcase
      end
      OPC_ADDI: begin
        dec.legal = 1'b1; dec.op = ALU_ADD; dec.trap = 1'b1;
        dec.use_imm = 1'b1; dec.dst = rt_f;
      end
      OPC_ADDIU: begin
        dec.legal = 1'b1; dec.op = ALU_ADD; dec.use_imm = 1'b1;
        dec.zext = ZEXT_UNSIGNED_IMM; dec.dst = rt_f;
      end
      OPC_SLTI: begin
        dec.legal = 1'b1; dec.op = ALU_SLT; dec.use_imm = 1'b1; dec.dst = rt_f;
      end
      OPC_SLTIU: begin
        dec.legal = 1'b1; dec.op = ALU_SLTU; dec.use_imm = 1'b1;
        dec.zext = ZEXT_UNSIGNED_IMM; dec.dst = rt_f;
      end
      default: dec.legal = 1'b0;
    endcase
    if (!dec.legal) begin
      dec = '0;
      dec.op = ALU_NONE;
    end
  end

endmodule

// File: rtl/arith_regfile.sv
module arith_regfile
  import arith_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   raddr_a,
  output logic [XLEN-1:0] rdata_a,
  input  logic [AW-1:0]   raddr_b,
  output logic [XLEN-1:0] rdata_b
);

  logic [NUM_REGS-1:0][XLEN-1:0] bank;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_cell
    if (g == 0) begin : g_zero
      assign bank[g] = '0;
    end else begin : g_store
      logic [XLEN-1:0] q;
      always_ff @(posedge clk) begin
        if (we && (waddr == AW'(g))) q <= wdata;
      end
      assign bank[g] = q;
    end
  end

  assign rdata_a = bank[raddr_a];
  assign rdata_b = bank[raddr_b];

endmodule

// File: rtl/arith_alu.sv
module arith_alu
  import arith_pkg::*;
(
  input  alu_op_e         op,
  input  logic            trap,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] result,
  output logic            ovf
);

  logic [XLEN-1:0] sum;
  logic [XLEN-1:0] diff;

  assign sum  = a + b;
  assign diff = a - b;

  always_comb begin
    result = '0;
    ovf    = 1'b0;
    unique case (op)
      ALU_ADD: begin
        result = sum;
        ovf    = trap && add_overflows(a, b, sum);
      end
      ALU_SUB: begin
        result = diff;
        ovf    = trap && sub_overflows(a, b, diff);
      end
      ALU_SLT:  result = XLEN'(less_signed(a, b));
      ALU_SLTU: result = XLEN'(a < b);
      default:  result = '0;
    endcase
  end

endmodule

// File: rtl/arith_core.sv
module arith_core
  import arith_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC          = '0,
  parameter int              PC_STEP           = 4,
  parameter bit              ZEXT_UNSIGNED_IMM = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  output logic [XLEN-1:0]   imem_addr,
  input  logic [XLEN-1:0]   imem_data,
  output logic              wb_en,
  output logic [REG_AW-1:0] wb_addr,
  output logic [XLEN-1:0]   wb_data,
  output logic              ovf_flag
);

  localparam int NUM_REGS = 1 << REG_AW;

  logic [XLEN-1:0]   pc_q;
  logic [XLEN-1:0]   pc_next;
  dec_t              dec;
  logic [REG_AW-1:0] rs_idx;
  logic [REG_AW-1:0] rt_idx;
  logic [XLEN-1:0]   rs_val;
  logic [XLEN-1:0]   rt_val;
  logic [XLEN-1:0]   imm_ext;
  logic [XLEN-1:0]   opnd_b;
  logic [XLEN-1:0]   alu_res;
  logic              alu_ovf;
  // Named events for the checker.
  logic              dec_legal;
  logic              wrap_arith;
  logic              cmp_op;

  assign pc_next = pc_q + XLEN'(PC_STEP);

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= pc_next;
  end

  assign imem_addr = pc_q;
  assign rs_idx    = imem_data[25:21];
  assign rt_idx    = imem_data[20:16];

  arith_decode #(.ZEXT_UNSIGNED_IMM(ZEXT_UNSIGNED_IMM)) u_dec (
    .instr (imem_data),
    .dec   (dec)
  );

  arith_regfile #(.NUM_REGS(NUM_REGS)) u_rf (
    .clk     (clk),
    .we      (wb_en),
    .waddr   (wb_addr),
    .wdata   (wb_data),
    .raddr_a (rs_idx),
    .rdata_a (rs_val),
    .raddr_b (rt_idx),
    .rdata_b (rt_val)
  );

  assign imm_ext = extend_imm(imem_data[IMM_W-1:0], dec.zext);
  assign opnd_b  = dec.use_imm ? imm_ext : rt_val;

  arith_alu u_alu (
    .op     (dec.op),
    .trap   (dec.trap),
    .a      (rs_val),
    .b      (opnd_b),
    .result (alu_res),
    .ovf    (alu_ovf)
  );

  assign ovf_flag = alu_ovf;
  assign wb_en    = dec.legal && !alu_ovf;
  assign wb_addr  = dec.dst;
  assign wb_data  = alu_res;

  assign dec_legal  = dec.legal;
  assign wrap_arith = dec.legal && !dec.trap && (dec.op inside {ALU_ADD, ALU_SUB});
  assign cmp_op     = dec.op inside {ALU_SLT, ALU_SLTU};

endmodule

// File: rtl/arith_core_chk.sv
module arith_core_chk
  import arith_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [XLEN-1:0]   imem_addr,
  input logic              wb_en,
  input logic [XLEN-1:0]   wb_data,
  input logic              ovf_flag,
  input logic              dec_legal,
  input logic              wrap_arith,
  input logic              cmp_op,
  input logic [REG_AW-1:0] rs_idx,
  input logic [XLEN-1:0]   rs_val,
  input logic [REG_AW-1:0] rt_idx,
  input logic [XLEN-1:0]   rt_val
);

  // R1
  pc_reset_chk: assert property (@(posedge clk) rst |=> imem_addr == '0);

  // R1
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> imem_addr == $past(imem_addr) + XLEN'(4));

  // R2
  zero_read_a_chk: assert property (@(posedge clk) disable iff (rst)
    rs_idx == '0 |-> rs_val == '0);

  // R2
  zero_read_b_chk: assert property (@(posedge clk) disable iff (rst)
    rt_idx == '0 |-> rt_val == '0);

  // R3
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !dec_legal |-> !wb_en && !ovf_flag);

  // R4
  wrap_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_arith |-> !ovf_flag);

  // R5
  ovf_blocks_wb_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |-> !wb_en);

  // R6
  cmp_bit_chk: assert property (@(posedge clk) disable iff (rst)
    cmp_op && wb_en |-> wb_data[XLEN-1:1] == '0);

endmodule

bind arith_core arith_core_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .imem_addr  (imem_addr),
  .wb_en      (wb_en),
  .wb_data    (wb_data),
  .ovf_flag   (ovf_flag),
  .dec_legal  (dec_legal),
  .wrap_arith (wrap_arith),
  .cmp_op     (cmp_op),
  .rs_idx     (rs_idx),
  .rs_val     (rs_val),
  .rt_idx     (rt_idx),
  .rt_val     (rt_val)
);

// File: tb/arith_core_tb_top.sv
module arith_core_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr;
  logic [31:0] imem_data = '0;
  logic        wb_en;
  logic [4:0]  wb_addr;
  logic [31:0] wb_data;
  logic        ovf_flag;

  int          n_checks = 0;
  int          n_errors = 0;
  bit          finished = 1'b0;
  logic [31:0] model_rf [32];
  logic [31:0] exp_pc = '0;

  always #4 clk = ~clk;

  arith_core dut_i (
    .clk       (clk),
    .rst       (rst),
    .imem_addr (imem_addr),
    .imem_data (imem_data),
    .wb_en     (wb_en),
    .wb_addr   (wb_addr),
    .wb_data   (wb_data),
    .ovf_flag  (ovf_flag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rs, input int rt, input int rd);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h00, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] opc, input int rs, input int rt, input logic [15:0] imm);
    return {opc, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] rd_reg(input logic [4:0] idx);
    return (idx == 0) ? 32'h0 : model_rf[idx];
  endfunction

  // Reference built on exact 64-bit arithmetic rather than sign-bit rules.
  function automatic void reference(input logic [31:0] ins, output bit en,
                                    output logic [4:0] dst, output logic [31:0] res,
                                    output bit ov);
    logic [5:0]  opc = ins[31:26];
    logic [5:0]  fn  = ins[5:0];
    logic [31:0] a   = rd_reg(ins[25:21]);
    logic [31:0] b;
    longint      sa, sb, exact;
    int          kind; // 0 none, 1 add, 2 sub, 3 slt, 4 sltu
    bit          trap;
    kind = 0; trap = 0; dst = '0; res = '0; en = 0; ov = 0;
    b = rd_reg(ins[20:16]);
    if (opc == 6'h00) begin
      dst = ins[15:11];
      case (fn)
        6'h20: begin kind = 1; trap = 1; end
        6'h21: kind = 1;
        6'h22: begin kind = 2; trap = 1; end
        6'h23: kind = 2;
        6'h2A: kind = 3;
        6'h2B: kind = 4;
        default: kind = 0;
      endcase
    end else if (opc >= 6'h08 && opc <= 6'h0B) begin
      dst = ins[20:16];
      b   = {{16{ins[15]}}, ins[15:0]};
      kind = (opc == 6'h08 || opc == 6'h09) ? 1 : (opc == 6'h0A) ? 3 : 4;
      trap = (opc == 6'h08);
    end
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (kind)
      1: exact = sa + sb;
      2: exact = sa - sb;
      3: exact = (sa < sb) ? 1 : 0;
      4: exact = ({32'h0, a} < {32'h0, b}) ? 1 : 0;
      default: exact = 0;
    endcase
    res = exact[31:0];
    if (kind == 0) begin
      dst = '0;
    end else begin
      ov = trap && (exact > 64'sd2147483647 || exact < -64'sd2147483648);
      en = !ov;
    end
  endfunction

  function automatic string tag_of(input logic [31:0] ins);
    logic [5:0] opc = ins[31:26];
    logic [5:0] fn  = ins[5:0];
    if (opc == 6'h00 && (fn == 6'h2A || fn == 6'h2B)) return "R6";
    if (opc == 6'h00 && fn >= 6'h20 && fn <= 6'h23) return "R4";
    if (opc == 6'h0A || opc == 6'h0B) return "R6";
    if (opc == 6'h08 || opc == 6'h09) return "R7";
    return "R3";
  endfunction

  // Drives one instruction at a falling edge, checks the combinational
  // outputs, then commits through the rising edge.
  task automatic exec(input logic [31:0] ins, input string req);
    bit          en, ov;
    logic [4:0]  dst;
    logic [31:0] res;
    imem_data = ins;
    #1;
    reference(ins, en, dst, res, ov);
    check(imem_addr == exp_pc, "R1", "fetch address", imem_addr, exp_pc);
    check(ovf_flag == ov, ov ? "R5" : req, "overflow flag", 32'(ovf_flag), 32'(ov));
    check(wb_en == en, req, "write enable", 32'(wb_en), 32'(en));
    if (en) begin
      check(wb_addr == dst, "R9", "write address", 32'(wb_addr), 32'(dst));
      check(wb_data == res, req, "write data", wb_data, res);
    end
    @(posedge clk);
    if (en && dst != 0) model_rf[dst] = res;
    exp_pc = exp_pc + 32'd4;
    @(negedge clk);
  endtask

  task automatic expect_reg(input int idx, input logic [31:0] val, input string req);
    // addu r0-target read-out: value appears on wb_data
    imem_data = enc_r(6'h21, idx, 0, 0);
    #1;
    check(wb_data == val, req, $sformatf("register r%0d read-out", idx), wb_data, val);
    exec(enc_r(6'h21, idx, 0, 0), req);
  endtask

  initial begin : watchdog
    #(8 * 200000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin : stim
    logic [5:0] fns [6];
    logic [5:0] iops [4];
    void'($urandom(32'd12345));
    fns  = '{6'h20, 6'h21, 6'h22, 6'h23, 6'h2A, 6'h2B};
    iops = '{6'h08, 6'h09, 6'h0A, 6'h0B};
    for (int i = 0; i < 32; i++) model_rf[i] = '0;

    // R1: reset holds the counter at zero.
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(imem_addr == 32'h0, "R1", "reset address", imem_addr, 32'h0);
    check(wb_en == 1'b0, "R3", "no-op word during reset", 32'(wb_en), 32'h0);
    rst = 1'b0;
    exp_pc = '0;

    // R7: seed every register with a sign-extended immediate.
    for (int r = 1; r < 32; r++)
      exec(enc_i(6'h08, 0, r, 16'($urandom)), "R7");

    // Build 0x80000000 in r1 and 0x7fffffff in r2, 1 in r3.
    exec(enc_i(6'h08, 0, 1, 16'h0001), "R7");
    exec(enc_i(6'h08, 0, 3, 16'h0001), "R7");
    for (int k = 0; k < 31; k++) exec(enc_r(6'h21, 1, 1, 1), "R4");
    exec(enc_r(6'h23, 1, 3, 2), "R4");
    check(model_rf[1] == 32'h8000_0000, "R4", "bench setup of minimum", model_rf[1], 32'h8000_0000);

    // R5: trapping add overflows, r4 untouched.
    exec(enc_i(6'h08, 0, 4, 16'h0055), "R7");
    exec(enc_r(6'h20, 2, 3, 4), "R5");
    expect_reg(4, 32'h0000_0055, "R5");
    // R4: addu wraps silently.
    exec(enc_r(6'h21, 2, 3, 4), "R4");
    expect_reg(4, 32'h8000_0000, "R4");
    // R8: negation via register 0.
    exec(enc_r(6'h22, 0, 3, 6), "R8");
    expect_reg(6, 32'hFFFF_FFFF, "R8");
    exec(enc_r(6'h22, 0, 1, 6), "R8");
    expect_reg(6, 32'hFFFF_FFFF, "R8");
    exec(enc_r(6'h23, 0, 1, 6), "R8");
    expect_reg(6, 32'h8000_0000, "R8");
    // R6: signed vs unsigned compare of the same pair.
    exec(enc_r(6'h2A, 1, 3, 7), "R6");
    expect_reg(7, 32'h1, "R6");
    exec(enc_r(6'h2B, 1, 3, 7), "R6");
    expect_reg(7, 32'h0, "R6");
    // R7: addi overflow vs addiu wrap; sign extension for sltiu.
    exec(enc_i(6'h08, 2, 8, 16'h0001), "R5");
    exec(enc_i(6'h09, 2, 8, 16'h0001), "R7");
    expect_reg(8, 32'h8000_0000, "R7");
    exec(enc_i(6'h0A, 3, 9, 16'hFFFF), "R6");
    expect_reg(9, 32'h0, "R6");
    exec(enc_i(6'h0B, 3, 9, 16'hFFFF), "R7");
    expect_reg(9, 32'h1, "R7");
    exec(enc_i(6'h09, 0, 9, 16'h8000), "R7");
    expect_reg(9, 32'hFFFF_8000, "R7");
    // R2: write to register 0 is accepted but leaves it at zero.
    exec(enc_i(6'h08, 0, 0, 16'h1234), "R2");
    exec(enc_r(6'h21, 0, 0, 10), "R2");
    expect_reg(10, 32'h0, "R2");
    // R3: illegal words are no-ops.
    exec({6'h3F, 26'h3FF_FFFF}, "R3");
    exec(enc_r(6'h3F, 1, 2, 11), "R3");
    exec(enc_i(6'h23, 1, 11, 16'h0000), "R3");
    // R9: back-to-back dependency.
    exec(enc_i(6'h08, 0, 12, 16'h0010), "R9");
    exec(enc_r(6'h21, 12, 12, 13), "R9");
    expect_reg(13, 32'h0000_0020, "R9");

    // R1: mid-run reset returns the counter to zero.
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(imem_addr == 32'h0, "R1", "address after mid-run reset", imem_addr, 32'h0);
    rst = 1'b0;
    exp_pc = '0;

    // Random mix.
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] ins;
      int sel = int'($urandom_range(0, 19));
      if (sel < 10)
        ins = enc_r(fns[$urandom_range(0, 5)], int'($urandom_range(0, 31)),
                    int'($urandom_range(0, 31)), int'($urandom_range(0, 31)));
      else if (sel < 18)
        ins = enc_i(iops[$urandom_range(0, 3)], int'($urandom_range(0, 31)),
                    int'($urandom_range(0, 31)), 16'($urandom));
      else
        ins = $urandom;
      exec(ins, tag_of(ins));
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule